// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block watches a small group of general-purpose input pins and turns their transitions into interrupt requests for a processor. Each pin can be set to request on a rising transition, a falling transition, or both. Every transition is first brought into the clock domain through a synchronising flop chain. It is then held in a per-edge pending bit until software acknowledges it, so short pulses are not lost while the processor is busy.

Software uses a simple word-wide register port with three locations. The enable word holds the rising-edge enables in its low byte and the falling-edge enables in the next byte up. The acknowledge word clears pending events when written, and reads back the raw pending state in the same layout. The vector-base word sets the interrupt vector number of pin 0. When one or more enabled events are pending, the block raises a single request and presents the vector of the lowest-numbered pin that has one.

Top module: `gpio_edge_irq`

## Requirements
- R1: There are seven pins, 0 to 6. In the enable word at address 0, bit n enables rising-edge requests for pin n and bit n+8 enables falling-edge requests for pin n. Each bit is stored independently, and a read returns the stored bits with every other bit as 0.
- R2: A pin transition sets its pending bit at the third rising clock edge after the input changes. A low-to-high change sets bit n and a high-to-low change sets bit n+8. This happens whether or not that edge is enabled.
- R3: `irq_req` is high exactly when some pending bit and the enable bit at the same position are both 1.
- R4: A write to address 1 clears every pending bit where the written data has a 1. Bits written as 0 keep their value.
- R5: If a pin edge and an acknowledge of the same pending bit fall in the same cycle, the bit stays set.
- R6: While `irq_req` is high, `irq_vector` equals the vector base plus the index of the lowest-numbered pin with an enabled pending event of either edge type, modulo 256.
- R7: The vector base is the low 8 bits of address 2, and it resets to 0x40. While `irq_req` is low, `irq_vector` equals the vector base.
- R8: After reset, the enable and pending bits are all 0 and `irq_req` is low.
- R9: Without a pin edge or an acknowledge, pending bits keep their value, including while enables change. A read of address 1 returns them in the enable-word layout, and a read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 7 | Asynchronous general-purpose input pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 8 | Vector number of the winning pin |

## Verification
The hardest case to reach is an acknowledge that lands on exactly the cycle in which a fresh edge on the same pin sets the bit it clears. The pin delay is three flops deep and the write takes effect one edge after the strobe. The bench therefore changes the pin on a falling clock edge and raises the acknowledge strobe two falling edges later, so that both take effect at the same rising edge. A pending bit that is already set before the edge shows whether the clear or the edge wins. The synchroniser latency is pinned down the same way, by reading the pending word one edge before and one edge after the expected set point.

// File: rtl/gpio_irq_pkg.sv
// Package: shared sizes and register addresses for the GPIO edge
// interrupt controller. Assumes the falling-edge field offset is at
// least the number of pins, so the two fields never overlap.
package gpio_irq_pkg;

    localparam int NUM_PINS   = 7;   // interrupt-capable input pins
    localparam int FALL_OFS   = 8;   // bit offset of the falling-edge field
    localparam int DATA_W     = 32;  // register port data width
    localparam int VEC_W      = 8;   // vector number width
    localparam int SYNC_DEPTH = 2;   // synchroniser flops per pin

    typedef enum logic [1:0] {
        ADDR_ENABLE = 2'd0,
        ADDR_ACK    = 2'd1,
        ADDR_VBASE  = 2'd2,
        ADDR_NONE   = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/gpio_edge_detect.sv
// Module: gpio_edge_detect
// Brings asynchronous pins through a flop chain and flags one-cycle
// rising and falling pulses by comparing the settled value with its
// value one cycle earlier. Assumes DEPTH >= 2. All flops reset to 0,
// so a pin held high through reset reports a rising edge afterwards.
module gpio_edge_detect #(
    parameter int LINES = 7,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pin_i,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);

    logic [DEPTH-1:0][LINES-1:0] chain_q;
    logic [LINES-1:0]            last_q;
    logic [LINES-1:0]            settled;

    assign settled = chain_q[DEPTH-1];

    // Shift pins through the synchroniser and remember the settled value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= '0;
        end else begin
            chain_q <= {chain_q[DEPTH-2:0], pin_i};
            last_q  <= settled;
        end
    end

    // Compare the settled value with last cycle's value.
    always_comb begin
        rise_o = settled & ~last_q;
        fall_o = ~settled & last_q;
    end

endmodule

// File: rtl/gpio_pend_bank.sv
// Module: gpio_pend_bank
// Holds one pending bit per edge per pin, packed as {fall, rise}.
// A set wins over a clear of the same bit in the same cycle.
// Assumes set and clear are single-cycle pulses from the clock domain.
module gpio_pend_bank #(
    parameter int BITS = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BITS-1:0] set_i,
    input  logic [BITS-1:0] clr_i,
    output logic [BITS-1:0] pend_o
);

    logic [BITS-1:0] pend_q;

    // Apply clears first, then let new edges override them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | set_i;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/gpio_vec_prio.sv
// Module: gpio_vec_prio
// Picks the lowest-numbered pin with an active request and adds its
// index to the vector base. With no request the vector is the base.
// The sum wraps modulo 2**VEC_W.
module gpio_vec_prio #(
    parameter int LINES = 7,
    parameter int VEC_W = 8
) (
    input  logic [LINES-1:0] active_i,
    input  logic [VEC_W-1:0] base_i,
    output logic             any_o,
    output logic [VEC_W-1:0] vector_o
);

    logic [VEC_W-1:0] win_idx;

    // Scan from the top so the lowest active index is kept last.
    always_comb begin
        win_idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (active_i[i]) begin
                win_idx = VEC_W'(i);
            end
        end
    end

    // Form the request and the vector number.
    always_comb begin
        any_o    = |active_i;
        vector_o = base_i + win_idx;
    end

endmodule

// File: rtl/gpio_edge_irq.sv
// Module: gpio_edge_irq (top)
// Per-pin edge interrupt controller with a three-word register port:
// enables (address 0), acknowledge/pending (address 1) and vector base
// (address 2). Writes take effect at the clock edge on which reg_wr is
// high; reads are combinational from reg_addr.
module gpio_edge_irq
    import gpio_irq_pkg::*;
#(
    parameter int                NPINS     = NUM_PINS,
    parameter int                FOFS      = FALL_OFS,
    parameter int                DW        = DATA_W,
    parameter int                VW        = VEC_W,
    parameter int                SDEPTH    = SYNC_DEPTH,
    parameter logic [VEC_W-1:0]  VBASE_RST = 8'h40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq_req,
    output logic [VW-1:0]    irq_vector
);

    localparam int PBITS = 2 * NPINS;

    logic [NPINS-1:0] rise_pulse;
    logic [NPINS-1:0] fall_pulse;
    logic [PBITS-1:0] edge_set;   // {fall, rise}
    logic [PBITS-1:0] clr_mask;   // {fall, rise}
    logic [PBITS-1:0] pend;       // {fall, rise}
    logic [PBITS-1:0] en_q;       // {fall, rise}
    logic [VW-1:0]    vbase_q;
    logic [NPINS-1:0] active;

    gpio_edge_detect #(
        .LINES (NPINS),
        .DEPTH (SDEPTH)
    ) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .rise_o (rise_pulse),
        .fall_o (fall_pulse)
    );

    assign edge_set = {fall_pulse, rise_pulse};

    // Decode an acknowledge write into the packed clear mask.
    always_comb begin
        clr_mask = '0;
        if (reg_wr && reg_addr == ADDR_ACK) begin
            clr_mask = {reg_wdata[FOFS +: NPINS], reg_wdata[NPINS-1:0]};
        end
    end

    gpio_pend_bank #(
        .BITS (PBITS)
    ) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (edge_set),
        .clr_i  (clr_mask),
        .pend_o (pend)
    );

    // Hold the enable and vector-base registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            vbase_q <= VBASE_RST;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_ENABLE) begin
                en_q <= {reg_wdata[FOFS +: NPINS], reg_wdata[NPINS-1:0]};
            end
            if (reg_addr == ADDR_VBASE) begin
                vbase_q <= reg_wdata[VW-1:0];
            end
        end
    end

    // Fold both edge types of each pin into one active flag.
    always_comb begin
        active = (pend[NPINS-1:0] & en_q[NPINS-1:0])
               | (pend[PBITS-1:NPINS] & en_q[PBITS-1:NPINS]);
    end

    gpio_vec_prio #(
        .LINES (NPINS),
        .VEC_W (VW)
    ) u_prio (
        .active_i (active),
        .base_i   (vbase_q),
        .any_o    (irq_req),
        .vector_o (irq_vector)
    );

    // Return the addressed register in the register-word layout.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_ENABLE: begin
                reg_rdata[NPINS-1:0]    = en_q[NPINS-1:0];
                reg_rdata[FOFS +: NPINS] = en_q[PBITS-1:NPINS];
            end
            ADDR_ACK: begin
                reg_rdata[NPINS-1:0]    = pend[NPINS-1:0];
                reg_rdata[FOFS +: NPINS] = pend[PBITS-1:NPINS];
            end
            ADDR_VBASE: reg_rdata[VW-1:0] = vbase_q;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_edge_irq_checker.sv
// Module: gpio_edge_irq_checker
// Clocked properties over the pending bank, the request and the vector
// of gpio_edge_irq. Bound to every instance of the top module below.
module gpio_edge_irq_checker #(
    parameter int LINES = 7,
    parameter int VW    = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2*LINES-1:0] pend,
    input logic [2*LINES-1:0] en,
    input logic [2*LINES-1:0] edge_set,
    input logic [2*LINES-1:0] clr_mask,
    input logic [VW-1:0]      vec_base,
    input logic               irq_req,
    input logic [VW-1:0]      irq_vector
);

    localparam int IW = $clog2(LINES);

    logic [LINES-1:0] act;
    logic [VW-1:0]    off;
    logic             winner_ok;

    // Independent view of which pins hold an enabled event.
    always_comb begin
        act = (pend[LINES-1:0] & en[LINES-1:0])
            | (pend[2*LINES-1:LINES] & en[2*LINES-1:LINES]);
        off = irq_vector - vec_base;
        winner_ok = 1'b0;
        if (off < VW'(LINES)) begin
            winner_ok = act[off[IW-1:0]]
                && ((act & ((LINES'(1) << off[IW-1:0]) - LINES'(1))) == '0);
        end
    end

    // R2: an edge always leaves its pending bit set.
    a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_set != '0) |=> ((pend & $past(edge_set)) == $past(edge_set)));

    // R4: an acknowledged bit without a competing edge is cleared.
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((pend & $past(clr_mask & ~edge_set)) == '0));

    // R9: with no edge and no acknowledge the pending bits hold.
    a_r9_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_set == '0 && clr_mask == '0) |=> $stable(pend));

    // R6: the vector names the lowest pin with an enabled event.
    a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> winner_ok);

    // R3: no request without an enabled pending event.
    a_r3_req_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |-> !irq_req);

    // R7: the idle vector is the base.
    a_r7_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_vector == vec_base));

endmodule

bind gpio_edge_irq gpio_edge_irq_checker #(
    .LINES (NPINS),
    .VW    (VW)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend       (pend),
    .en         (en_q),
    .edge_set   (edge_set),
    .clr_mask   (clr_mask),
    .vec_base   (vbase_q),
    .irq_req    (irq_req),
    .irq_vector (irq_vector)
);

// File: tb/gpio_edge_irq_test.sv
module gpio_edge_irq_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  pin_in = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gpio_edge_irq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_req    (irq_req),
        .irq_vector (irq_vector)
    );

    // Each entry: {enable word [15:0], pin pattern [7:0]}.
    localparam logic [23:0] VEC_TABLE [6] = '{
        {16'h0001, 8'h01},
        {16'h0000, 8'h10},
        {16'h7F00, 8'h7F},
        {16'h0060, 8'h70},
        {16'h7F7F, 8'h48},
        {16'h0040, 8'h40}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // Expected vector computed from the requirement text.
    function automatic logic [7:0] exp_vec(input logic [15:0] en, input logic [15:0] pe,
                                           input logic [7:0] base);
        logic [6:0] a;
        a = (pe[6:0] & en[6:0]) | (pe[14:8] & en[14:8]);
        for (int i = 0; i < 7; i++) begin
            if (a[i]) return base + 8'(i);
        end
        return base;
    endfunction

    function automatic logic exp_req(input logic [15:0] en, input logic [15:0] pe);
        return ((pe & en & 16'h7F7F) != 16'h0000);
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [15:0] en, pe;
        logic [6:0]  pins;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 / R7: reset state.
        rd(2'd0, d); check("R8 enable reset", d, 32'h0);
        rd(2'd1, d); check("R8 pending reset", d, 32'h0);
        check("R8 req reset", {31'h0, irq_req}, 32'h0);
        rd(2'd2, d); check("R7 vbase reset", d, 32'h40);
        check("R7 idle vector", {24'h0, irq_vector}, 32'h40);

        // R1: enable storage and unimplemented bits.
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R1 enable readback", d, 32'h7F7F);
        wr(2'd0, 32'h0000_2A15);
        rd(2'd0, d); check("R1 enable independent bits", d, 32'h2A15);
        rd(2'd3, d); check("R9 unused address", d, 32'h0);
        wr(2'd0, 32'h0);

        // R2: latency of exactly three rising edges.
        @(negedge clk); pin_in = 7'h04;
        @(posedge clk); @(posedge clk);
        rd(2'd1, d); check("R2 not yet pending", d, 32'h0);
        @(posedge clk);
        rd(2'd1, d); check("R2 pending at third edge", d, 32'h0004);
        @(negedge clk); pin_in = 7'h00;
        settle();
        rd(2'd1, d); check("R2 falling sets n+8", d, 32'h0404);
        wr(2'd1, 32'h7F7F);

        // Table walk: R2, R3, R6 under several patterns.
        for (int k = 0; k < 6; k++) begin
            en   = VEC_TABLE[k][23:8];
            pins = VEC_TABLE[k][6:0];
            wr(2'd0, {16'h0, en});
            @(negedge clk); pin_in = pins;
            settle();
            pe = {9'h0, pins};
            rd(2'd1, d); check("R2 table pending", d, {16'h0, pe});
            check("R3 table req", {31'h0, irq_req}, {31'h0, exp_req(en, pe)});
            check("R6 table vector", {24'h0, irq_vector}, {24'h0, exp_vec(en, pe, 8'h40)});
            @(negedge clk); pin_in = 7'h00;
            settle();
            pe = {1'b0, pins, 1'b0, pins};
            rd(2'd1, d); check("R2 table both edges", d, {16'h0, pe});
            check("R6 table vector both", {24'h0, irq_vector}, {24'h0, exp_vec(en, pe, 8'h40)});
            wr(2'd1, 32'h7F7F);
            rd(2'd1, d); check("R4 table cleared", d, 32'h0);
        end

        // R9: pending holds while enables change; R3 follows enables.
        wr(2'd0, 32'h0);
        @(negedge clk); pin_in = 7'h08;
        settle();
        check("R3 masked no req", {31'h0, irq_req}, 32'h0);
        wr(2'd0, 32'h0800);
        check("R3 other edge enabled no req", {31'h0, irq_req}, 32'h0);
        wr(2'd0, 32'h0008);
        rd(2'd1, d); check("R9 pending held", d, 32'h0008);
        check("R3 req after enable", {31'h0, irq_req}, 32'h1);

        // R4: write-0 no effect, write-1 clears only that bit.
        @(negedge clk); pin_in = 7'h00;
        settle();
        wr(2'd1, 32'h0);
        rd(2'd1, d); check("R4 zero write no effect", d, 32'h0808);
        wr(2'd1, 32'h0008);
        rd(2'd1, d); check("R4 clear one bit", d, 32'h0800);
        wr(2'd1, 32'h7F7F);

        // R5: edge and acknowledge of the same bit in one cycle.
        @(negedge clk); pin_in = 7'h04;
        settle();
        @(negedge clk); pin_in = 7'h00;
        settle();
        rd(2'd1, d); check("R5 setup", d, 32'h0404);
        @(negedge clk); pin_in = 7'h04;          // N0
        @(negedge clk);                          // N1
        @(negedge clk);                          // N2: strobe for the edge at k+2
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0004;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        rd(2'd1, d); check("R5 edge beats clear", d, 32'h0404);
        @(negedge clk); pin_in = 7'h00;
        settle();
        wr(2'd1, 32'h7F7F);

        // R6 / R7: new base, wrap-around, falling-only enable.
        wr(2'd2, 32'hFFFF_FFFC);
        rd(2'd2, d); check("R7 vbase write", d, 32'hFC);
        check("R7 idle vector new base", {24'h0, irq_vector}, 32'hFC);
        wr(2'd0, 32'h6000);
        @(negedge clk); pin_in = 7'h60;
        @(negedge clk); pin_in = 7'h00;
        settle();
        check("R3 falling-only req", {31'h0, irq_req}, 32'h1);
        check("R6 vector wraps", {24'h0, irq_vector}, 32'h01);
        wr(2'd1, 32'h2000);
        check("R6 next line after clear", {24'h0, irq_vector}, 32'h02);
        wr(2'd1, 32'h7F7F);
        check("R3 req drops", {31'h0, irq_req}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule